// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is a single-channel transmit engine that walks a circular list of 16-byte descriptors held in system memory. Software fills descriptors, marks each one as owned by hardware, and then tells the engine how far it may go by writing a tail address. While running, the engine reads a descriptor's flag word and then its buffer address. It streams the buffer out as 32-bit beats, writes the flag word back with the ownership bit cleared, and steps to the next ring slot. When the last slot is done it wraps to the first.

The engine stops fetching once its current descriptor address equals the tail address. It continues as soon as software moves the tail on. If it reads a descriptor that software has not handed over, it parks in a suspended state and makes no further memory traffic until the tail register is written again. Clearing the run bit lets the descriptor in progress finish and then stops the engine. Setting the run bit again rewinds the engine to the ring base.

The memory port is a simple single-port interface. Read data is valid in the cycle after the request. The stream output has no backpressure.

Top module: `txring_engine`

## Requirements
- R1: After reset, strm_valid, mem_req and eng_busy are low and cur_addr is 0.
- R2: Register writes decode reg_addr as follows. 0 is control, with bit 0 as the run bit. 1 is the ring base byte address, whose bits 3:0 are forced to zero. 2 is the ring length minus one. 3 is the tail byte address.
- R3: The engine reads word 3 (at byte offset 12) and then word 0 (the buffer byte address). In word 3, bit 31 is ownership (1 means hardware owns the descriptor), bit 29 marks the first segment, bit 28 marks the last segment, and bits 14:0 hold the byte length. Words 1 and 2 are never read.
- R4: A descriptor of length L produces ceil(L/4) beats. The beats carry consecutive 32-bit buffer words starting at the buffer address. strm_bytes is 4 on every beat except the last, where it is ((L-1) mod 4)+1. A length of 0 produces no beats. Read data is taken from mem_rdata one cycle after each request.
- R5: strm_sof is high on the first beat exactly when word 3 bit 29 is set. strm_eof is high on the last beat exactly when word 3 bit 28 is set. Both are low on every other beat.
- R6: After the last beat, word 3 is written back once with bit 31 cleared and every other bit unchanged. No other descriptor word is written, and the write never coincides with a stream beat.
- R7: cur_addr equals base + 16 x index. A fetch starts only while the run bit is set and cur_addr differs from the tail address.
- R8: After the slot whose index equals the programmed length-minus-one, the index returns to 0.
- R9: A descriptor read with bit 31 clear produces no beats and no write-back. The engine raises eng_suspended and leaves the index unchanged. It stays quiet until the tail register is written, with any value, and then fetches that descriptor again.
- R10: Clearing the run bit during a descriptor lets that descriptor complete, including write-back. No further descriptor is then fetched, even if the tail is ahead.
- R11: Writing the run bit from 0 to 1 returns the index to 0 before the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read request |
| strm_valid | output | 1 | Stream beat valid |
| strm_data | output | 32 | Stream beat data |
| strm_bytes | output | 3 | Valid bytes in the beat (1..4) |
| strm_sof | output | 1 | First beat of a frame |
| strm_eof | output | 1 | Last beat of a frame |
| eng_busy | output | 1 | A descriptor is being processed |
| eng_suspended | output | 1 | Parked on a descriptor not owned by hardware |
| cur_addr | output | 32 | Byte address of the current descriptor |

## Verification
A wrong ring index shows up at cur_addr in the cycle after the write-back. It also shows up as a write-back to the wrong descriptor, so every sweep step compares both. A wrong beat counter or length decode changes the number of beats or the strm_bytes value on the final beat of that same descriptor. A lost ownership or stop decision is caught within a few cycles, either as memory traffic during suspension or as an extra write-back after stopping. A missed rewind shows as a cur_addr other than the base immediately after the run bit is set again.

// File: rtl/txring_pkg.sv
package txring_pkg;

    localparam int OWN_BIT = 31;
    localparam int SOF_BIT = 29;
    localparam int EOF_BIT = 28;
    localparam int LEN_W   = 15;
    localparam int FLAG_OFS = 12;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_BASE = 2'd1;
    localparam logic [1:0] RA_LAST = 2'd2;
    localparam logic [1:0] RA_TAIL = 2'd3;

    typedef enum logic [2:0] {
        W_IDLE,
        W_FLAGRD,
        W_FLAGCHK,
        W_BUFWT,
        W_XFER,
        W_DRAIN,
        W_WBACK,
        W_SUSP
    } walk_st_e;

endpackage

// File: rtl/txring_cfg.sv
module txring_cfg
    import txring_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic             run_o,
    output logic             kick_o,
    output logic [31:0]      base_o,
    output logic [IDX_W-1:0] last_o,
    output logic [31:0]      tail_o,
    output logic             tail_wr_o
);

    typedef struct packed {
        logic             run;
        logic             kick;
        logic [31:0]      base;
        logic [IDX_W-1:0] last;
        logic [31:0]      tail;
        logic             tail_wr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d         = cfg_q;
        cfg_d.kick    = 1'b0;
        cfg_d.tail_wr = 1'b0;
        if (reg_we) begin
            case (reg_addr)
                RA_CTRL: begin
                    cfg_d.run  = reg_wdata[0];
                    cfg_d.kick = reg_wdata[0] && !cfg_q.run;
                end
                RA_BASE: cfg_d.base = {reg_wdata[31:4], 4'b0000};
                RA_LAST: cfg_d.last = reg_wdata[IDX_W-1:0];
                default: begin
                    cfg_d.tail    = reg_wdata;
                    cfg_d.tail_wr = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign run_o     = cfg_q.run;
    assign kick_o    = cfg_q.kick;
    assign base_o    = cfg_q.base;
    assign last_o    = cfg_q.last;
    assign tail_o    = cfg_q.tail;
    assign tail_wr_o = cfg_q.tail_wr;

    assert_kick_from_stopped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        kick_o |-> run_o && !$past(run_o));

endmodule

// File: rtl/txring_ptr.sv
module txring_ptr #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      base_i,
    input  logic [IDX_W-1:0] last_i,
    input  logic [31:0]      tail_i,
    input  logic             adv_i,
    input  logic             clr_i,
    output logic [31:0]      cur_addr_o,
    output logic             avail_o
);

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clr_i)
            idx_d = '0;
        else if (adv_i)
            idx_d = (idx_q == last_i) ? '0 : idx_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign cur_addr_o = base_i + 32'({idx_q, 4'b0000});
    assign avail_o    = (cur_addr_o != tail_i);

    assert_wrap_to_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clr_i && idx_q == last_i) |=> idx_q == '0);

    assert_rewind_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> idx_q == '0);

endmodule

// File: rtl/txring_walker.sv
module txring_walker
    import txring_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run_i,
    input  logic        kick_i,
    input  logic        avail_i,
    input  logic        tail_wr_i,
    input  logic [31:0] cur_addr_i,
    input  logic [31:0] mem_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic        strm_valid,
    output logic [31:0] strm_data,
    output logic [2:0]  strm_bytes,
    output logic        strm_sof,
    output logic        strm_eof,
    output logic        adv_o,
    output logic        clr_o,
    output logic        busy_o,
    output logic        susp_o
);

    typedef struct packed {
        walk_st_e         st;
        logic [31:0]      flags;
        logic [31:0]      bufa;
        logic [LEN_W-1:0] issued;
        logic             beat_v;
        logic             beat_first;
        logic             beat_last;
        logic [2:0]       beat_bytes;
        logic             rew_pend;
    } walk_t;

    walk_t w_d, w_q;

    logic [LEN_W-1:0] byte_len;
    logic [LEN_W+1:0] len_rnd;
    logic [LEN_W-1:0] n_beats;
    logic [2:0]       tail_bytes;
    logic             final_issue;

    always_comb begin
        byte_len    = w_q.flags[LEN_W-1:0];
        len_rnd     = {2'b00, byte_len} + (LEN_W+2)'(3);
        n_beats     = len_rnd[LEN_W+1:2];
        tail_bytes  = (byte_len[1:0] == 2'd0) ? 3'd4 : {1'b0, byte_len[1:0]};
        final_issue = (w_q.issued == n_beats - 1'b1);
    end

    always_comb begin
        w_d        = w_q;
        w_d.beat_v = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = cur_addr_i;
        mem_wdata  = '0;
        adv_o      = 1'b0;
        clr_o      = 1'b0;
        case (w_q.st)
            W_IDLE: begin
                if (w_q.rew_pend) begin
                    clr_o        = 1'b1;
                    w_d.rew_pend = 1'b0;
                end else if (run_i && avail_i && !kick_i) begin
                    w_d.st = W_FLAGRD;
                end
            end
            W_FLAGRD: begin
                mem_req  = 1'b1;
                mem_addr = cur_addr_i + 32'(FLAG_OFS);
                w_d.st   = W_FLAGCHK;
            end
            W_FLAGCHK: begin
                w_d.flags = mem_rdata;
                if (mem_rdata[OWN_BIT]) begin
                    mem_req  = 1'b1;
                    mem_addr = cur_addr_i;
                    w_d.st   = W_BUFWT;
                end else begin
                    w_d.st = W_SUSP;
                end
            end
            W_BUFWT: begin
                w_d.bufa   = mem_rdata;
                w_d.issued = '0;
                w_d.st     = (n_beats == '0) ? W_WBACK : W_XFER;
            end
            W_XFER: begin
                mem_req        = 1'b1;
                mem_addr       = w_q.bufa + 32'({w_q.issued, 2'b00});
                w_d.beat_v     = 1'b1;
                w_d.beat_first = (w_q.issued == '0);
                w_d.beat_last  = final_issue;
                w_d.beat_bytes = final_issue ? tail_bytes : 3'd4;
                w_d.issued     = w_q.issued + 1'b1;
                if (final_issue) w_d.st = W_DRAIN;
            end
            W_DRAIN: begin
                w_d.st = W_WBACK;
            end
            W_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_addr_i + 32'(FLAG_OFS);
                mem_wdata = w_q.flags;
                mem_wdata[OWN_BIT] = 1'b0;
                adv_o     = 1'b1;
                w_d.st    = W_IDLE;
            end
            W_SUSP: begin
                if (tail_wr_i || !run_i) w_d.st = W_IDLE;
            end
            default: w_d.st = W_IDLE;
        endcase
        if (kick_i) w_d.rew_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q    <= '0;
            w_q.st <= W_IDLE;
        end else begin
            w_q <= w_d;
        end
    end

    assign strm_valid = w_q.beat_v;
    assign strm_data  = mem_rdata;
    assign strm_bytes = w_q.beat_v ? w_q.beat_bytes : 3'd0;
    assign strm_sof   = w_q.beat_v && w_q.beat_first && w_q.flags[SOF_BIT];
    assign strm_eof   = w_q.beat_v && w_q.beat_last && w_q.flags[EOF_BIT];
    assign busy_o     = (w_q.st != W_IDLE) && (w_q.st != W_SUSP);
    assign susp_o     = (w_q.st == W_SUSP);

    assert_wb_after_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !strm_valid && (mem_addr[3:0] == 4'hC));

    assert_beat_follows_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strm_valid |-> $past(mem_req && !mem_we));

    assert_susp_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        susp_o |-> !mem_req && !strm_valid);

    assert_fetch_needs_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(run_i));

endmodule

// File: rtl/txring_engine.sv
module txring_engine #(
    parameter int IDX_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        strm_valid,
    output logic [31:0] strm_data,
    output logic [2:0]  strm_bytes,
    output logic        strm_sof,
    output logic        strm_eof,
    output logic        eng_busy,
    output logic        eng_suspended,
    output logic [31:0] cur_addr
);

    logic             run, kick, tail_wr, avail, adv, clr;
    logic [31:0]      base, tail;
    logic [IDX_W-1:0] last;

    txring_cfg #(.IDX_W(IDX_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .run_o     (run),
        .kick_o    (kick),
        .base_o    (base),
        .last_o    (last),
        .tail_o    (tail),
        .tail_wr_o (tail_wr)
    );

    txring_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_i     (base),
        .last_i     (last),
        .tail_i     (tail),
        .adv_i      (adv),
        .clr_i      (clr),
        .cur_addr_o (cur_addr),
        .avail_o    (avail)
    );

    txring_walker u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .kick_i     (kick),
        .avail_i    (avail),
        .tail_wr_i  (tail_wr),
        .cur_addr_i (cur_addr),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .strm_valid (strm_valid),
        .strm_data  (strm_data),
        .strm_bytes (strm_bytes),
        .strm_sof   (strm_sof),
        .strm_eof   (strm_eof),
        .adv_o      (adv),
        .clr_o      (clr),
        .busy_o     (eng_busy),
        .susp_o     (eng_suspended)
    );

endmodule

// File: tb/test_txring_engine.sv
module test_txring_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        strm_valid, strm_sof, strm_eof, eng_busy, eng_suspended;
    logic [31:0] strm_data, cur_addr;
    logic [2:0]  strm_bytes;

    always #2.5 clk = ~clk;

    txring_engine i_txring_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .strm_valid(strm_valid), .strm_data(strm_data), .strm_bytes(strm_bytes),
        .strm_sof(strm_sof), .strm_eof(strm_eof), .eng_busy(eng_busy),
        .eng_suspended(eng_suspended), .cur_addr(cur_addr)
    );

    localparam logic [31:0] BASE = 32'h40;
    localparam logic [31:0] PAT  = 32'hC0DE_0000;

    logic [31:0] mem [256];
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:2]];
        end
    end

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int cap_n = 0;
    int wb_cnt = 0;
    int rq_cnt = 0;
    logic [31:0] cap_data [64];
    logic [2:0]  cap_bytes [64];
    logic        cap_sof [64];
    logic        cap_eof [64];
    logic [31:0] wb_addr;

    always @(negedge clk) begin
        if (rst_n) begin
            if (strm_valid && cap_n < 64) begin
                cap_data[cap_n]  = strm_data;
                cap_bytes[cap_n] = strm_bytes;
                cap_sof[cap_n]   = strm_sof;
                cap_eof[cap_n]   = strm_eof;
                cap_n++;
            end
            if (mem_req) rq_cnt++;
            if (mem_req && mem_we) begin
                wb_cnt++;
                wb_addr = mem_addr;
            end
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic clr_cap();
        cap_n = 0; wb_cnt = 0; rq_cnt = 0;
    endtask

    task automatic put_desc(input int idx, input logic [31:0] bufa, input logic [31:0] flags);
        int w;
        w = (BASE >> 2) + 4 * idx;
        mem[w]     = bufa;
        mem[w + 1] = 32'hDEAD_0001;
        mem[w + 2] = 32'hDEAD_0002;
        mem[w + 3] = flags;
    endtask

    task automatic wait_at(input logic [31:0] t, input string req);
        int n;
        n = 0;
        while (!(!eng_busy && !eng_suspended && cur_addr == t) && n < 600) begin
            @(negedge clk);
            n++;
        end
        chk(n < 600, req, cur_addr, t);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] slot(input int idx);
        return BASE + 32'(16 * (idx % 4));
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = PAT + 32'(i);
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!strm_valid && !mem_req && !eng_busy, "R1 idle outputs", {strm_valid, mem_req, eng_busy}, 0);
        chk(cur_addr == 0, "R1 cur_addr", cur_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: base low bits forced to zero
        wr_reg(2'd1, BASE | 32'h7);
        wr_reg(2'd2, 32'd3);
        chk(cur_addr == BASE, "R2 base alignment", cur_addr, BASE);
        wr_reg(2'd3, BASE);
        wr_reg(2'd0, 32'd1);
        clr_cap();
        repeat (10) @(negedge clk);
        // R7: tail equal to current means nothing fetched
        chk(rq_cnt == 0 && !eng_busy, "R7 no fetch at tail", rq_cnt, 0);

        // Sweep of lengths 0..13 over a 4-slot ring (R3 R4 R5 R6 R7 R8)
        for (int j = 0; j < 14; j++) begin
            logic [31:0] bufa, flags, exp;
            int nb, lb;
            bufa  = 32'h100 + 32'(j * 32);
            flags = 32'h8000_0000 | 32'h0010_0000 | 32'(j);
            if (j[0]) flags[29] = 1'b1;
            if (j[1]) flags[28] = 1'b1;
            put_desc(j % 4, bufa, flags);
            clr_cap();
            wr_reg(2'd3, slot(j + 1));
            wait_at(slot(j + 1), "R8 advance and wrap");
            nb = (j + 3) / 4;
            lb = (j == 0) ? 0 : ((j - 1) % 4) + 1;
            chk(cap_n == nb, "R4 beat count", cap_n, nb);
            for (int k = 0; k < cap_n && k < nb; k++) begin
                exp = PAT + (bufa >> 2) + 32'(k);
                chk(cap_data[k] == exp, "R4 beat data", cap_data[k], exp);
                chk(cap_bytes[k] == ((k == nb - 1) ? 3'(lb) : 3'd4), "R4 beat bytes",
                    32'(cap_bytes[k]), (k == nb - 1) ? lb : 4);
                chk(cap_sof[k] == (k == 0 && j[0]), "R5 sof", 32'(cap_sof[k]), 32'(k == 0 && j[0]));
                chk(cap_eof[k] == (k == nb - 1 && j[1]), "R5 eof", 32'(cap_eof[k]), 32'(k == nb - 1 && j[1]));
            end
            exp = flags & 32'h7FFF_FFFF;
            chk(mem[(slot(j) >> 2) + 3] == exp, "R6 flag write-back", mem[(slot(j) >> 2) + 3], exp);
            chk(wb_cnt == 1 && wb_addr == slot(j) + 12, "R6 single write to word 3", wb_addr, slot(j) + 12);
            chk(mem[slot(j) >> 2] == bufa && mem[(slot(j) >> 2) + 2] == 32'hDEAD_0002,
                "R3 other words untouched", mem[slot(j) >> 2], bufa);
        end
        // current slot index 14%4 = 2

        // R9: descriptor not owned
        put_desc(2, 32'h300, 32'h3000_0004);
        clr_cap();
        wr_reg(2'd3, slot(3));
        repeat (12) @(negedge clk);
        chk(eng_suspended == 1'b1, "R9 suspended", 32'(eng_suspended), 1);
        chk(cap_n == 0 && wb_cnt == 0, "R9 no data no write", cap_n + wb_cnt, 0);
        chk(cur_addr == slot(2), "R9 index held", cur_addr, slot(2));
        rq_cnt = 0;
        repeat (8) @(negedge clk);
        chk(rq_cnt == 0, "R9 quiet while suspended", rq_cnt, 0);
        mem[(slot(2) >> 2) + 3] = 32'hB000_0004;
        wr_reg(2'd3, slot(3));
        wait_at(slot(3), "R9 resume after tail write");
        chk(cap_n == 1 && cap_data[0] == PAT + 32'h300 / 4, "R9 resumed data", cap_data[0], PAT + 32'h300 / 4);
        chk(wb_cnt == 1, "R9 resumed write-back", wb_cnt, 1);

        // R10: stop during a long descriptor
        put_desc(3, 32'h200, 32'h9000_0028);
        put_desc(0, 32'h340, 32'h8000_0004);
        put_desc(1, 32'h360, 32'h8000_0005);
        clr_cap();
        wr_reg(2'd3, slot(2));
        while (cap_n == 0) @(negedge clk);
        wr_reg(2'd0, 32'd0);
        repeat (40) @(negedge clk);
        chk(cap_n == 10, "R10 current descriptor completes", cap_n, 10);
        chk(wb_cnt == 1, "R10 no further fetch", wb_cnt, 1);
        chk(cur_addr == slot(0) && !eng_busy, "R10 stopped at next slot", cur_addr, slot(0));

        // R11: restart rewinds to base
        clr_cap();
        wr_reg(2'd0, 32'd1);
        wait_at(slot(2), "R11 run resumes");
        chk(wb_cnt == 2, "R11 two descriptors done", wb_cnt, 2);
        wr_reg(2'd0, 32'd0);
        repeat (3) @(negedge clk);
        wr_reg(2'd0, 32'd1);
        repeat (12) @(negedge clk);
        chk(cur_addr == BASE, "R11 index rewound", cur_addr, BASE);
        chk(eng_suspended == 1'b1, "R11 refetch of returned slot suspends", 32'(eng_suspended), 1);

        summary();
    end

endmodule